// File: doc/BRIEF.md
# Two-Delta Stride Result Predictor

This block guesses the next result of a register-writing instruction from the results that same instruction produced before. A direct-mapped table, indexed and tagged by the instruction address, holds one entry per instruction. Each entry stores the latest result, a candidate stride, a committed stride and a small saturating confidence counter. The guess is the latest result plus the committed stride. The candidate stride is rewritten on every update. The committed stride only adopts a new difference after that same difference has shown up on two updates in a row. A single odd value therefore does not disturb a running stride.

A lookup port is purely combinational. It takes an instruction address and returns a hit flag, the predicted value and a confidence flag that tells the pipeline whether the guess is worth using. An update port takes an address and the actual result, one per clock. Each update is classified as one of four outcome kinds:
- OUT_IDLE: no update.
- OUT_ALLOC: tag miss, so the entry is claimed.
- OUT_HIT_GOOD: hit, and the stored guess matched.
- OUT_HIT_BAD: hit, and the stored guess missed.

Each kind selects how the entry is rewritten at the next clock edge.

Top module: `stride2d_predictor`

## Requirements
- R1: After reset no lookup hits, and a missing lookup returns `lkp_hit`=0, `lkp_pred`=0 and `lkp_confident`=0.
- R2: Entry index is address bits [ALIGN+IDX_W-1:ALIGN]; tag is the next TAG_W bits above them. A lookup hits only when the entry is valid and its stored tag equals the address tag. An update to a different tag at the same index evicts the old instruction.
- R3: An update that misses allocates the entry with last value = result, both strides 0 and counter 0, so the next lookup predicts the result itself with `lkp_confident`=0.
- R4: On a hit the prediction is last value + committed stride, modulo 2^32.
- R5: Every update on a hit sets the candidate stride to (result − last value) modulo 2^32, and sets the last value to the result.
- R6: The committed stride takes the new difference only when that difference equals the candidate stride held before the update; otherwise it keeps its value.
- R7: On a hit, the counter rises by one, saturating at 3, when the result equals the prediction made with the pre-update committed stride. Otherwise it clears to 0.
- R8: `lkp_confident` is 1 exactly when the lookup hits and the entry's counter is 2 or more.
- R9: A lookup in the same cycle as an update to the same entry sees the state before that update; the update becomes visible from the next cycle.
- R10: A constant result sequence gives a committed stride of 0, so the constant is predicted and gains confidence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_addr | input | ADDR_W | Instruction address to look up |
| lkp_hit | output | 1 | Lookup address has a live entry |
| lkp_pred | output | DATA_W | Predicted result (0 on a miss) |
| lkp_confident | output | 1 | Prediction may be used |
| upd_valid | input | 1 | Update strobe |
| upd_addr | input | ADDR_W | Address of the instruction that completed |
| upd_value | input | DATA_W | Actual result of that instruction |

## Verification
The bench builds the block with its defaults: 32-bit addresses and data, 64 entries, 6-bit tags, word-aligned indexing and a 2-bit counter. With these values, addresses one tag step apart collide on a single index, so eviction is easy to reach. Values near 2^32 reach the stride wrap. Four updates bring the counter to saturation and the confidence threshold.

// File: rtl/svp_pkg.sv
package svp_pkg;

    // Classification of one update cycle; picks how the entry is rewritten.
    typedef enum logic [1:0] {
        OUT_IDLE     = 2'd0,
        OUT_ALLOC    = 2'd1,
        OUT_HIT_GOOD = 2'd2,
        OUT_HIT_BAD  = 2'd3
    } upd_kind_e;

endpackage

// File: rtl/svp_addr_split.sv
module svp_addr_split #(
    parameter int ADDR_W = 32,
    parameter int ALIGN  = 2,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    localparam int TAG_LO = ALIGN + IDX_W;

    initial begin
        if (TAG_LO + TAG_W > ADDR_W)
            $error("address too narrow for index and tag");
    end

    // Index sits just above the alignment bits, tag just above the index (R2)
    assign idx = addr[ALIGN +: IDX_W];
    assign tag = addr[TAG_LO +: TAG_W];
endmodule

// File: rtl/svp_entry_table.sv
module svp_entry_table #(
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    parameter int CONF_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    // lookup read port
    input  logic [IDX_W-1:0]  ra_idx,
    output logic              ra_vld,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_last,
    output logic [DATA_W-1:0] ra_s2,
    output logic [CONF_W-1:0] ra_conf,
    // update read port
    input  logic [IDX_W-1:0]  rb_idx,
    output logic              rb_vld,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_last,
    output logic [DATA_W-1:0] rb_s1,
    output logic [DATA_W-1:0] rb_s2,
    output logic [CONF_W-1:0] rb_conf,
    // write port
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_last,
    input  logic [DATA_W-1:0] wr_s1,
    input  logic [DATA_W-1:0] wr_s2,
    input  logic [CONF_W-1:0] wr_conf
);
    localparam int DEPTH = 1 << IDX_W;

    logic              vld_q  [DEPTH];
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [DATA_W-1:0] last_q [DEPTH];
    logic [DATA_W-1:0] s1_q   [DEPTH];
    logic [DATA_W-1:0] s2_q   [DEPTH];
    logic [CONF_W-1:0] conf_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                vld_q[i]  <= 1'b0;
                tag_q[i]  <= '0;
                last_q[i] <= '0;
                s1_q[i]   <= '0;
                s2_q[i]   <= '0;
                conf_q[i] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_idx]  <= 1'b1;
            tag_q[wr_idx]  <= wr_tag;
            last_q[wr_idx] <= wr_last;
            s1_q[wr_idx]   <= wr_s1;
            s2_q[wr_idx]   <= wr_s2;
            conf_q[wr_idx] <= wr_conf;
        end
    end

    // Reads see the stored state; a write lands at the edge (R9)
    always_comb begin
        ra_vld  = vld_q[ra_idx];
        ra_tag  = tag_q[ra_idx];
        ra_last = last_q[ra_idx];
        ra_s2   = s2_q[ra_idx];
        ra_conf = conf_q[ra_idx];
        rb_vld  = vld_q[rb_idx];
        rb_tag  = tag_q[rb_idx];
        rb_last = last_q[rb_idx];
        rb_s1   = s1_q[rb_idx];
        rb_s2   = s2_q[rb_idx];
        rb_conf = conf_q[rb_idx];
    end

    // R9: a write is visible on the update read port one cycle later
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rb_idx == wr_idx) ##1 (rb_idx == $past(wr_idx)) |->
            (rb_vld && rb_last == $past(wr_last) && rb_s2 == $past(wr_s2))); // R9
endmodule

// File: rtl/svp_update_calc.sv
module svp_update_calc
    import svp_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    parameter int CONF_W = 2
) (
    input  logic              upd_valid,
    input  logic [TAG_W-1:0]  upd_tag,
    input  logic [DATA_W-1:0] upd_value,
    input  logic              cur_vld,
    input  logic [TAG_W-1:0]  cur_tag,
    input  logic [DATA_W-1:0] cur_last,
    input  logic [DATA_W-1:0] cur_s1,
    input  logic [DATA_W-1:0] cur_s2,
    input  logic [CONF_W-1:0] cur_conf,
    output upd_kind_e         kind,
    output logic              wr_en,
    output logic [DATA_W-1:0] nxt_last,
    output logic [DATA_W-1:0] nxt_s1,
    output logic [DATA_W-1:0] nxt_s2,
    output logic [CONF_W-1:0] nxt_conf
);
    localparam logic [CONF_W-1:0] CONF_MAX = '1;

    logic              hit;
    logic [DATA_W-1:0] guess;
    logic [DATA_W-1:0] delta;

    always_comb begin
        hit   = cur_vld && (cur_tag == upd_tag);
        guess = cur_last + cur_s2;       // judged with the old committed stride
        delta = upd_value - cur_last;    // wraps modulo 2^DATA_W

        if (!upd_valid)              kind = OUT_IDLE;
        else if (!hit)               kind = OUT_ALLOC;
        else if (guess == upd_value) kind = OUT_HIT_GOOD;
        else                         kind = OUT_HIT_BAD;
    end

    always_comb begin
        wr_en    = 1'b0;
        nxt_last = cur_last;
        nxt_s1   = cur_s1;
        nxt_s2   = cur_s2;
        nxt_conf = cur_conf;
        unique case (kind)
            OUT_IDLE: ;
            OUT_ALLOC: begin
                wr_en    = 1'b1;
                nxt_last = upd_value;
                nxt_s1   = '0;
                nxt_s2   = '0;
                nxt_conf = '0;
            end
            OUT_HIT_GOOD, OUT_HIT_BAD: begin
                wr_en    = 1'b1;
                nxt_last = upd_value;
                nxt_s1   = delta;
                nxt_s2   = (delta == cur_s1) ? delta : cur_s2;
                if (kind == OUT_HIT_GOOD)
                    nxt_conf = (cur_conf == CONF_MAX) ? CONF_MAX : cur_conf + 1'b1;
                else
                    nxt_conf = '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/stride2d_predictor.sv
module stride2d_predictor
    import svp_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 6,
    parameter int TAG_W   = 6,
    parameter int ALIGN   = 2,
    parameter int CONF_W  = 2,
    parameter int CONF_TH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lkp_addr,
    output logic              lkp_hit,
    output logic [DATA_W-1:0] lkp_pred,
    output logic              lkp_confident,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [DATA_W-1:0] upd_value
);
    localparam logic [CONF_W-1:0] TH       = CONF_W'(CONF_TH);
    localparam logic [CONF_W-1:0] CONF_MAX = '1;

    logic [IDX_W-1:0]  l_idx, u_idx;
    logic [TAG_W-1:0]  l_tag, u_tag;
    logic              ra_vld, rb_vld;
    logic [TAG_W-1:0]  ra_tag, rb_tag;
    logic [DATA_W-1:0] ra_last, ra_s2, rb_last, rb_s1, rb_s2;
    logic [CONF_W-1:0] ra_conf, rb_conf;
    upd_kind_e         kind;
    logic              wr_en;
    logic [DATA_W-1:0] nxt_last, nxt_s1, nxt_s2;
    logic [CONF_W-1:0] nxt_conf;

    svp_addr_split #(.ADDR_W(ADDR_W), .ALIGN(ALIGN), .IDX_W(IDX_W), .TAG_W(TAG_W))
        u_lsplit (.addr(lkp_addr), .idx(l_idx), .tag(l_tag));
    svp_addr_split #(.ADDR_W(ADDR_W), .ALIGN(ALIGN), .IDX_W(IDX_W), .TAG_W(TAG_W))
        u_usplit (.addr(upd_addr), .idx(u_idx), .tag(u_tag));

    svp_entry_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .CONF_W(CONF_W))
    u_table (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(l_idx), .ra_vld(ra_vld), .ra_tag(ra_tag), .ra_last(ra_last),
        .ra_s2(ra_s2), .ra_conf(ra_conf),
        .rb_idx(u_idx), .rb_vld(rb_vld), .rb_tag(rb_tag), .rb_last(rb_last),
        .rb_s1(rb_s1), .rb_s2(rb_s2), .rb_conf(rb_conf),
        .wr_en(wr_en), .wr_idx(u_idx), .wr_tag(u_tag), .wr_last(nxt_last),
        .wr_s1(nxt_s1), .wr_s2(nxt_s2), .wr_conf(nxt_conf)
    );

    svp_update_calc #(.TAG_W(TAG_W), .DATA_W(DATA_W), .CONF_W(CONF_W)) u_calc (
        .upd_valid(upd_valid), .upd_tag(u_tag), .upd_value(upd_value),
        .cur_vld(rb_vld), .cur_tag(rb_tag), .cur_last(rb_last), .cur_s1(rb_s1),
        .cur_s2(rb_s2), .cur_conf(rb_conf),
        .kind(kind), .wr_en(wr_en), .nxt_last(nxt_last), .nxt_s1(nxt_s1),
        .nxt_s2(nxt_s2), .nxt_conf(nxt_conf)
    );

    always_comb begin
        lkp_hit       = ra_vld && (ra_tag == l_tag);
        lkp_pred      = lkp_hit ? (ra_last + ra_s2) : '0;
        lkp_confident = lkp_hit && (ra_conf >= TH);
    end

    // ---------------- assertions ----------------
    logic chk_hit;
    assign chk_hit = rb_vld && (rb_tag == u_tag);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lkp_hit); // R1
    AST_ALLOC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !chk_hit) |->
            (nxt_last == upd_value && nxt_s1 == '0 && nxt_s2 == '0 && nxt_conf == '0)); // R3
    AST_S2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && chk_hit && (upd_value - rb_last) != rb_s1) |-> nxt_s2 == rb_s2); // R6
    AST_CONF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && chk_hit && (rb_last + rb_s2) != upd_value) |-> nxt_conf == '0); // R7
    AST_CONF_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && chk_hit && (rb_last + rb_s2) == upd_value && rb_conf == CONF_MAX)
            |-> nxt_conf == CONF_MAX); // R7
    AST_CONF_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_confident |-> lkp_hit); // R8
endmodule

// File: tb/stride2d_predictor_tb.sv
module stride2d_predictor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 6;
    localparam int TAG_W = 6;
    localparam int ALIGN = 2;
    localparam int DEPTH = 1 << IDX_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lkp_addr = '0;
    logic        lkp_hit;
    logic [31:0] lkp_pred;
    logic        lkp_confident;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic [31:0] upd_value = '0;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // behavioural reference state
    bit        m_vld  [DEPTH];
    bit [5:0]  m_tag  [DEPTH];
    bit [31:0] m_last [DEPTH];
    bit [31:0] m_s1   [DEPTH];
    bit [31:0] m_s2   [DEPTH];
    int        m_conf [DEPTH];

    stride2d_predictor u_dut (
        .clk(clk), .rst_n(rst_n), .lkp_addr(lkp_addr), .lkp_hit(lkp_hit),
        .lkp_pred(lkp_pred), .lkp_confident(lkp_confident), .upd_valid(upd_valid),
        .upd_addr(upd_addr), .upd_value(upd_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int idx_of(input logic [31:0] a);
        return int'(a[ALIGN +: IDX_W]);
    endfunction

    // one cycle: drive at negedge, compare against model, advance model
    task automatic step(input logic [31:0] la, input bit uv, input logic [31:0] ua,
                        input logic [31:0] uval);
        int li, ui;
        bit eh, uh, good;
        bit [31:0] ep, d;
        @(negedge clk);
        lkp_addr = la; upd_valid = uv; upd_addr = ua; upd_value = uval;
        #1;
        li = idx_of(la);
        eh = m_vld[li] && m_tag[li] == la[ALIGN+IDX_W +: TAG_W];
        ep = eh ? m_last[li] + m_s2[li] : 32'd0;
        check("R2 hit", {31'd0, lkp_hit}, {31'd0, eh});
        check("R4 pred", lkp_pred, ep);
        check("R8 confident", {31'd0, lkp_confident}, {31'd0, eh && m_conf[li] >= 2});
        if (uv && rst_n) begin
            ui = idx_of(ua);
            uh = m_vld[ui] && m_tag[ui] == ua[ALIGN+IDX_W +: TAG_W];
            if (!uh) begin
                m_vld[ui] = 1; m_tag[ui] = ua[ALIGN+IDX_W +: TAG_W];
                m_last[ui] = uval; m_s1[ui] = 0; m_s2[ui] = 0; m_conf[ui] = 0;
            end else begin
                good = (m_last[ui] + m_s2[ui]) == uval;
                d = uval - m_last[ui];
                if (d == m_s1[ui]) m_s2[ui] = d;
                m_s1[ui] = d;
                m_last[ui] = uval;
                m_conf[ui] = good ? ((m_conf[ui] == 3) ? 3 : m_conf[ui] + 1) : 0;
            end
        end
    endtask

    task automatic upd(input logic [31:0] a, input logic [31:0] v);
        step(a, 1'b1, a, v);
    endtask

    task automatic look(input logic [31:0] a);
        step(a, 1'b0, 32'd0, 32'd0);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
                finish_run();
            end
        end
    end

    localparam logic [31:0] A_ADDR = 32'h0000_1000; // idx 0, tag 0x10
    localparam logic [31:0] B_ADDR = 32'h0000_1100; // idx 0, tag 0x11
    localparam logic [31:0] C_ADDR = 32'h0000_1004; // idx 1
    localparam logic [31:0] D_ADDR = 32'h0000_1008; // idx 2

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        for (int i = 0; i < DEPTH; i++) begin
            m_vld[i] = 0; m_tag[i] = 0; m_last[i] = 0; m_s1[i] = 0; m_s2[i] = 0; m_conf[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        look(A_ADDR);
        check("R1 no hit after reset", {31'd0, lkp_hit}, 32'd0);
        check("R1 pred zero on miss", lkp_pred, 32'd0);

        // R3: allocation predicts the value itself
        upd(A_ADDR, 32'd100);
        look(A_ADDR);
        check("R3 alloc pred", lkp_pred, 32'd100);
        check("R3 alloc not confident", {31'd0, lkp_confident}, 32'd0);

        // R5/R6: first difference only reaches the candidate stride
        upd(A_ADDR, 32'd105);
        look(A_ADDR);
        check("R6 single diff keeps stride", lkp_pred, 32'd105);
        upd(A_ADDR, 32'd110);
        look(A_ADDR);
        check("R6 repeated diff commits", lkp_pred, 32'd115);

        // R7/R8: confidence build-up
        upd(A_ADDR, 32'd115);
        look(A_ADDR);
        check("R7 one good not confident", {31'd0, lkp_confident}, 32'd0);
        upd(A_ADDR, 32'd120);
        look(A_ADDR);
        check("R8 confident at two", {31'd0, lkp_confident}, 32'd1);
        upd(A_ADDR, 32'd125);
        upd(A_ADDR, 32'd130);
        upd(A_ADDR, 32'd135);
        look(A_ADDR);
        check("R7 saturated confident", {31'd0, lkp_confident}, 32'd1);
        upd(A_ADDR, 32'd999);
        look(A_ADDR);
        check("R7 wrong clears", {31'd0, lkp_confident}, 32'd0);
        check("R6 odd value keeps stride", lkp_pred, 32'd1004);

        // R10: constant sequence
        upd(C_ADDR, 32'd7);
        upd(C_ADDR, 32'd7);
        upd(C_ADDR, 32'd7);
        look(C_ADDR);
        check("R10 constant pred", lkp_pred, 32'd7);
        check("R10 constant confident", {31'd0, lkp_confident}, 32'd1);

        // R9: same-cycle lookup sees pre-update state
        step(C_ADDR, 1'b1, C_ADDR, 32'd50);
        check("R9 pre-update pred", lkp_pred, 32'd7);
        check("R9 pre-update confident", {31'd0, lkp_confident}, 32'd1);
        look(C_ADDR);
        check("R9 update visible", {31'd0, lkp_confident}, 32'd0);

        // R4/R5: wrap-around stride
        upd(D_ADDR, 32'hFFFF_FFFE);
        upd(D_ADDR, 32'hFFFF_FFFF);
        upd(D_ADDR, 32'h0000_0000);
        look(D_ADDR);
        check("R4 wrap pred", lkp_pred, 32'd1);

        // R2: tag conflict evicts
        upd(B_ADDR, 32'd50);
        look(A_ADDR);
        check("R2 evicted miss", {31'd0, lkp_hit}, 32'd0);
        look(B_ADDR);
        check("R2 new owner pred", lkp_pred, 32'd50);

        // mixed traffic compared against the model every cycle
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a, v;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = {18'd0, lfsr[3], 1'b1, 4'd0, 2'd0, lfsr[6:4], 1'b0, 2'd0};
            if (lfsr[9:8] == 2'd0) v = {16'd0, lfsr};
            else v = m_last[idx_of(a)] + {28'd0, lfsr[11:10], 2'd0};
            step({18'd0, lfsr[7], 1'b1, 4'd0, 2'd0, lfsr[14:12], 1'b0, 2'd0},
                 lfsr[15] | lfsr[2], a, v);
        end

        finish_run();
    end
endmodule